// File: doc/BRIEF.md
# Unaligned Little-Endian Byte Memory

A unified program and data store of 4096 bytes with a 32-bit word port that accepts any byte address. A word read gathers four consecutive bytes, least significant byte at the base address. A word write spreads the word over the same four bytes and commits all of them on one clock edge. The word port takes a full 32-bit address. Any access whose last byte would lie beyond the array raises a fault, and a faulting access does not touch the memory.

Internally the array is split into four byte-wide banks interleaved on the two low address bits. This lets an unaligned word reach each bank exactly once per access, with a row and a lane rotation taken from the base address. A separate byte-wide fetch port reads one byte per cycle through a second read path on every bank and has its own bounds check. A byte-wide load port fills the array from a testbench, and on a collision with the word port it takes priority for its byte.

Top module: `uword_mem`

## Requirements
- R1: While rst_ni is low every byte of the array is cleared to 0x00, so every in-range word and byte read returns zero after reset.
- R2: For addr_i = a with a <= 4092, rdata_o equals {m[a+3], m[a+2], m[a+1], m[a]} in the same cycle (combinational read), for every byte offset a mod 4.
- R3: With we_i high and addr_i = a <= 4092, the rising clock edge writes wdata_i[7:0] to m[a], wdata_i[15:8] to m[a+1], wdata_i[23:16] to m[a+2] and wdata_i[31:24] to m[a+3]; all other bytes keep their values.
- R4: fault_o is high exactly when the full 32-bit addr_i is greater than 4092, including any address with a bit set in positions 31..12.
- R5: While fault_o is high rdata_o is 0x00000000, and a write with we_i high changes no byte of the array.
- R6: fetch_data_o equals m[fetch_addr_i] combinationally for fetch_addr_i <= 4095, whatever the word port is doing.
- R7: fetch_fault_o is high exactly when the 32-bit fetch_addr_i is greater than 4095, and fetch_data_o is 0x00 while it is high.
- R8: With bd_we_i high the rising edge writes bd_data_i to m[bd_addr_i]; when the same edge also has a word write covering that byte, the bd_data_i value is the one kept.
- R9: Writing 0x1234ABCD at address 25 leaves 0xCD at 25, 0xAB at 26, 0x34 at 27 and 0x12 at 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears the array |
| addr_i | input | 32 | Word port byte address |
| we_i | input | 1 | Word write enable |
| wdata_i | input | 32 | Word write data |
| rdata_o | output | 32 | Word read data, little-endian |
| fault_o | output | 1 | Word access out of range |
| fetch_addr_i | input | 32 | Fetch port byte address |
| fetch_data_o | output | 8 | Fetch port byte |
| fetch_fault_o | output | 1 | Fetch address out of range |
| bd_we_i | input | 1 | Load port write enable |
| bd_addr_i | input | 12 | Load port byte address |
| bd_data_i | input | 8 | Load port byte |

## Verification
The assertions check on every cycle the fault thresholds of both ports, the zeroed outputs during a fault, the agreement between the fetch byte and the low byte of the word read at the same address, the readback of a word written to an address held stable, and the stability of a fetched byte across a faulting write. The bench scenarios show the lane rotation at all four byte offsets, the fact that writes leave neighbouring bytes untouched, the reset clear, the priority of the load port on a collision, and the full-width address decoding with high address bits set, all against a byte-level model of the array.

// File: rtl/uword_mem_pkg.sv
package uword_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/uword_mem_bank.sv
// One byte-wide bank: two write ports (port b wins), two combinational reads.
module uword_mem_bank
  import uword_mem_pkg::*;
#(
  parameter int unsigned ROWS  = 1024,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wa_en_i,
  input  logic [ROW_W-1:0] wa_row_i,
  input  byte_t            wa_data_i,
  input  logic             wb_en_i,
  input  logic [ROW_W-1:0] wb_row_i,
  input  byte_t            wb_data_i,
  input  logic [ROW_W-1:0] ra_row_i,
  output byte_t            ra_data_o,
  input  logic [ROW_W-1:0] rb_row_i,
  output byte_t            rb_data_o
);
  byte_t mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < int'(ROWS); r++) mem_q[r] <= '0;
    end else begin
      if (wa_en_i) mem_q[wa_row_i] <= wa_data_i;
      if (wb_en_i) mem_q[wb_row_i] <= wb_data_i;
    end
  end

  assign ra_data_o = mem_q[ra_row_i];
  assign rb_data_o = mem_q[rb_row_i];
endmodule

// File: rtl/uword_mem_bounds.sv
// Full-width range checks for the word and fetch ports.
module uword_mem_bounds #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned LANES     = 4
) (
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              word_fault_o,
  output logic              fetch_fault_o
);
  localparam logic [ADDR_W-1:0] WORD_LAST  = ADDR_W'(MEM_BYTES - LANES);
  localparam logic [ADDR_W-1:0] FETCH_LAST = ADDR_W'(MEM_BYTES - 1);

  assign word_fault_o  = word_addr_i  > WORD_LAST;
  assign fetch_fault_o = fetch_addr_i > FETCH_LAST;
endmodule

// File: rtl/uword_mem_router.sv
// Maps a byte base address onto per-bank rows and rotates data lanes.
module uword_mem_router
  import uword_mem_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned LANES     = 4,
  localparam int unsigned IDX_W  = $clog2(MEM_BYTES),
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = IDX_W - LANE_W,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic [IDX_W-1:0]             base_i,
  input  logic [WORD_W-1:0]            wdata_i,
  input  byte_t [LANES-1:0]            bank_rdata_i,
  output logic [LANES-1:0][ROW_W-1:0]  bank_row_o,
  output byte_t [LANES-1:0]            bank_wdata_o,
  output logic [WORD_W-1:0]            rdata_o
);
  logic [LANE_W-1:0] lane_off;
  assign lane_off = base_i[LANE_W-1:0];

  // bank b holds byte k of the word where (base + k) mod LANES == b
  always_comb begin
    for (int b = 0; b < int'(LANES); b++) begin
      logic [LANE_W-1:0] k;
      k = LANE_W'(b) - lane_off;
      bank_row_o[b]   = ROW_W'((base_i + IDX_W'(k)) >> LANE_W);
      bank_wdata_o[b] = wdata_i[int'(k)*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    for (int k = 0; k < int'(LANES); k++) begin
      logic [LANE_W-1:0] bsel;
      bsel = lane_off + LANE_W'(k);
      rdata_o[k*BYTE_W +: BYTE_W] = bank_rdata_i[bsel];
    end
  end
endmodule

// File: rtl/uword_mem.sv
module uword_mem
  import uword_mem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned LANES     = 4,
  localparam int unsigned IDX_W  = $clog2(MEM_BYTES),
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned ROW_W  = IDX_W - LANE_W,
  localparam int unsigned ROWS   = MEM_BYTES / LANES,
  localparam int unsigned WORD_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              fault_o,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [BYTE_W-1:0] fetch_data_o,
  output logic              fetch_fault_o,
  input  logic              bd_we_i,
  input  logic [IDX_W-1:0]  bd_addr_i,
  input  logic [BYTE_W-1:0] bd_data_i
);
  logic word_fault, fetch_fault;

  uword_mem_bounds #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .LANES(LANES)
  ) u_bounds (
    .word_addr_i  (addr_i),
    .fetch_addr_i (fetch_addr_i),
    .word_fault_o (word_fault),
    .fetch_fault_o(fetch_fault)
  );

  logic [LANES-1:0][ROW_W-1:0] word_row;
  byte_t [LANES-1:0]           word_wbyte;
  byte_t [LANES-1:0]           word_rbyte;
  byte_t [LANES-1:0]           fetch_rbyte;
  logic [WORD_W-1:0]           word_rdata;

  uword_mem_router #(
    .MEM_BYTES(MEM_BYTES), .LANES(LANES)
  ) u_router (
    .base_i      (addr_i[IDX_W-1:0]),
    .wdata_i     (wdata_i),
    .bank_rdata_i(word_rbyte),
    .bank_row_o  (word_row),
    .bank_wdata_o(word_wbyte),
    .rdata_o     (word_rdata)
  );

  logic              word_wr_en;
  logic [LANE_W-1:0] bd_bank;
  logic [ROW_W-1:0]  bd_row;
  logic [LANE_W-1:0] fetch_bank;
  logic [ROW_W-1:0]  fetch_row;

  assign word_wr_en = we_i && !word_fault;
  assign bd_bank    = bd_addr_i[LANE_W-1:0];
  assign bd_row     = bd_addr_i[IDX_W-1:LANE_W];
  assign fetch_bank = fetch_addr_i[LANE_W-1:0];
  assign fetch_row  = fetch_addr_i[IDX_W-1:LANE_W];

  for (genvar b = 0; b < int'(LANES); b++) begin : g_bank
    uword_mem_bank #(.ROWS(ROWS)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wa_en_i  (word_wr_en),
      .wa_row_i (word_row[b]),
      .wa_data_i(word_wbyte[b]),
      .wb_en_i  (bd_we_i && (bd_bank == LANE_W'(b))),
      .wb_row_i (bd_row),
      .wb_data_i(bd_data_i),
      .ra_row_i (word_row[b]),
      .ra_data_o(word_rbyte[b]),
      .rb_row_i (fetch_row),
      .rb_data_o(fetch_rbyte[b])
    );
  end

  assign fault_o       = word_fault;
  assign rdata_o       = word_fault ? '0 : word_rdata;
  assign fetch_fault_o = fetch_fault;
  assign fetch_data_o  = fetch_fault ? '0 : fetch_rbyte[fetch_bank];
endmodule

// File: rtl/uword_mem_chk.sv
module uword_mem_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned MEM_BYTES = 4096,
  parameter int unsigned LANES     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              fault_o,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [7:0]        fetch_data_o,
  input logic              fetch_fault_o,
  input logic              bd_we_i
);
  localparam logic [ADDR_W-1:0] WLAST = ADDR_W'(MEM_BYTES - LANES);
  localparam logic [ADDR_W-1:0] FLAST = ADDR_W'(MEM_BYTES - 1);

  a_r4_fault_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (addr_i > WLAST));

  a_r5_fault_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> rdata_o == '0);

  a_r5_fault_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && fault_o && !bd_we_i && !fetch_fault_o)
      |=> (!$stable(fetch_addr_i) || $stable(fetch_data_o)));

  a_r3_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !fault_o && !bd_we_i)
      |=> (!$stable(addr_i) || rdata_o == $past(wdata_i)));

  a_r6_fetch_matches_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && fetch_addr_i == addr_i) |-> fetch_data_o == rdata_o[7:0]);

  a_r7_fetch_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_fault_o == (fetch_addr_i > FLAST));

  a_r7_fetch_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_fault_o |-> fetch_data_o == '0);
endmodule

bind uword_mem uword_mem_chk #(
  .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .LANES(LANES)
) u_chk (.*);

// File: tb/uword_mem_test.sv
`timescale 1ns/1ps
module uword_mem_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        fault_o;
  logic [31:0] fetch_addr_i = '0;
  logic [7:0]  fetch_data_o;
  logic        fetch_fault_o;
  logic        bd_we_i = 1'b0;
  logic [11:0] bd_addr_i = '0;
  logic [7:0]  bd_data_i = '0;

  always #2.5 clk_i = ~clk_i;

  uword_mem uut (.*);

  logic [7:0] m [4096];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    if (a > 32'd4092) return '0;
    return {m[a+3], m[a+2], m[a+1], m[a]};
  endfunction

  function automatic logic exp_fault(input logic [31:0] a);
    return a > 32'd4092;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [31:0] a);
    addr_i = a;
    #1;
    chk(req, rdata_o, exp_word(a));
    chk(req, {31'd0, fault_o}, {31'd0, exp_fault(a)});
  endtask

  task automatic fb(input string req, input logic [31:0] a);
    fetch_addr_i = a;
    #1;
    chk(req, {24'd0, fetch_data_o}, (a > 32'd4095) ? 32'd0 : {24'd0, m[a]});
    chk(req, {31'd0, fetch_fault_o}, {31'd0, a > 32'd4095});
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a <= 32'd4092)
      for (int k = 0; k < 4; k++) m[a+k] = d[k*8 +: 8];
  endtask

  task automatic bd(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bd_addr_i = a; bd_data_i = d; bd_we_i = 1'b1;
    @(negedge clk_i);
    bd_we_i = 1'b0;
    m[a] = d;
  endtask

  initial begin
    void'($urandom(32'h0005_eed1));
    for (int i = 0; i < 4096; i++) m[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1: cleared while in reset
    rd("R1", 32'd0);
    rd("R1", 32'd4092);
    fb("R1", 32'd2049);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: directed little-endian store
    wr(32'd25, 32'h1234ABCD);
    fb("R9", 32'd25); fb("R9", 32'd26); fb("R9", 32'd27); fb("R9", 32'd28);
    fb("R3", 32'd24); fb("R3", 32'd29);
    for (int o = 24; o < 28; o++) rd("R2", o);

    // R8: load port fills the array
    for (int i = 0; i < 4096; i++) begin
      @(negedge clk_i);
      bd_addr_i = 12'(i); bd_data_i = 8'($urandom); bd_we_i = 1'b1;
      m[i] = bd_data_i;
    end
    @(negedge clk_i);
    bd_we_i = 1'b0;
    for (int i = 0; i < 40; i++) fb("R8", $urandom_range(4095, 0));

    // R2, R6: random reads at every offset, fetch independent of word port
    for (int i = 0; i < 300; i++) begin
      rd("R2", $urandom_range(4092, 0));
      fb("R6", $urandom_range(4095, 0));
    end

    // R3: random writes, neighbours intact
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a;
      a = $urandom_range(4092, 0);
      wr(a, $urandom);
      rd("R3", a);
      if (a > 0) fb("R3", a - 1);
      if (a < 4091) fb("R3", a + 4);
    end

    // R4: boundaries and upper address bits
    rd("R4", 32'd4092);
    rd("R4", 32'd4093);
    rd("R4", 32'd4096);
    rd("R4", 32'h8000_0000);
    rd("R4", 32'h0001_0019);
    rd("R4", 32'hFFFF_FFFF);

    // R5: faulting writes leave memory alone
    wr(32'd4093, 32'hDEAD_BEEF);
    fb("R5", 32'd4093); fb("R5", 32'd4094); fb("R5", 32'd4095);
    rd("R5", 32'd4092);
    wr(32'h0001_0019, 32'hCAFE_F00D);
    for (int o = 25; o < 29; o++) fb("R5", o);
    rd("R5", 32'h0001_0019);

    // R7: fetch bounds
    fb("R7", 32'd4095);
    fb("R7", 32'd4096);
    fb("R7", 32'h8000_0FFF);

    // R8: collision, load port byte wins
    @(negedge clk_i);
    addr_i = 32'd101; wdata_i = 32'hA1B2C3D4; we_i = 1'b1;
    bd_addr_i = 12'd103; bd_data_i = 8'h5A; bd_we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; bd_we_i = 1'b0;
    for (int k = 0; k < 4; k++) m[101+k] = wdata_i[k*8 +: 8];
    m[103] = 8'h5A;
    rd("R8", 32'd101);
    fb("R8", 32'd103);
    rd("R8", 32'd100);

    // R1: reset clears again
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 4096; i++) m[i] = '0;
    #1;
    rd("R1", 32'd101);
    fb("R1", 32'd4095);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule